// File: doc/BRIEF.md
# Rotation-Based Byte-Serial AES S-box

This block computes the AES forward substitution of one byte in eight clock cycles and uses just one single-bit nonlinear function. Multiplicative inversion in GF(2^8) commutes with cyclic rotation when field elements are written in a normal basis. Because of this, one output coordinate of the normal-basis inverse is enough. The operand is rotated one position per cycle, and each cycle's coordinate value is one more bit of the inverse.

A start strobe captures the input byte and changes it into the normal basis. Eight cycles of rotate-and-collect follow. The gathered bits go back to the polynomial basis (modulus x^8+x^4+x^3+x+1), and the affine output map with constant 0x63 is applied. A one-cycle done strobe marks the result. The output register keeps the result until the next accepted byte starts to overwrite it.

Top module: `rot_sbox`

## Requirements
- R1: After reset, busy and done are 0 and dout is 0x63, which is the substitution of a zero inverse.
- R2: When busy is 0, a start sampled high at a rising edge loads din, and busy is 1 in the cycle that follows.
- R3: done is high for exactly one cycle. That cycle comes right after the eight busy cycles of an operation, and busy is 0 in it.
- R4: In the done cycle, dout equals the AES S-box of the loaded byte: the GF(2^8) inverse modulo 0x11B, then the AES affine map with constant 0x63. This holds for all 256 inputs.
- R5: Input 0x00 gives 0x63, because zero is mapped to zero before the affine step.
- R6: A start while busy is 1 has no effect. The result and the done timing still follow the byte loaded first.
- R7: While busy is 0, dout does not change, whatever din and start do.
- R8: A start given in the done cycle is accepted, so operations can run back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load strobe for din, honoured only when idle |
| din | input | 8 | Byte to substitute |
| busy | output | 1 | High during the eight collection cycles |
| done | output | 1 | One-cycle pulse when dout holds a new result |
| dout | output | 8 | Substituted byte |

## Verification
The checker tests the protocol on every cycle. It checks that busy rises after an accepted start and that done is a single pulse that only follows exactly eight busy cycles. It also checks that dout cannot move while the block is idle. Whether dout holds the correct substitution can only be shown by the bench. The bench compares all 256 inputs, plus random ones, against a reference built from exhaustive inverse search. It also drives starts that arrive mid-operation and back-to-back starts.

// File: rtl/rot_sbox.sv
module rot_sbox (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] din,
  output logic       busy,
  output logic       done,
  output logic [7:0] dout
);

  localparam int N = 8;
  localparam int CW = $clog2(N);

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, aa;
    p = '0;
    aa = a;
    for (int i = 0; i < N; i++) begin
      if (b[i]) p ^= aa;
      aa = {aa[6:0], 1'b0} ^ (aa[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  // an element of trace one generates a normal basis when the degree is a power of two
  function automatic logic [7:0] find_normal();
    logic [7:0] t, acc;
    for (int b = 2; b < 256; b++) begin
      t = 8'(b);
      acc = t;
      for (int k = 1; k < N; k++) begin
        t = gf_mul(t, t);
        acc ^= t;
      end
      if (acc == 8'h01) return 8'(b);
    end
    return 8'h00;
  endfunction

  localparam logic [7:0] BETA = find_normal();

  function automatic logic [63:0] conj_cols(input logic [7:0] b);
    logic [63:0] c;
    logic [7:0] t;
    t = b;
    c = '0;
    for (int i = 0; i < N; i++) begin
      c[8*i +: 8] = t;
      t = gf_mul(t, t);
    end
    return c;
  endfunction

  localparam logic [63:0] N2P_M = conj_cols(BETA);

  function automatic logic [7:0] n2p(input logic [7:0] a);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < N; i++) if (a[i]) r ^= N2P_M[8*i +: 8];
    return r;
  endfunction

  function automatic logic [63:0] p2n_cols();
    logic [63:0] c;
    c = '0;
    for (int k = 0; k < N; k++)
      for (int v = 0; v < 256; v++)
        if (n2p(8'(v)) == (8'h01 << k)) c[8*k +: 8] = 8'(v);
    return c;
  endfunction

  localparam logic [63:0] P2N_M = p2n_cols();

  function automatic logic [7:0] p2n(input logic [7:0] a);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < N; i++) if (a[i]) r ^= P2N_M[8*i +: 8];
    return r;
  endfunction

  // x^254 = x^2 * x^4 * ... * x^128
  function automatic logic [7:0] inv_pow(input logic [7:0] x);
    logic [7:0] sq, r;
    sq = x;
    r = 8'h01;
    for (int i = 1; i < N; i++) begin
      sq = gf_mul(sq, sq);
      r = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic coord0(input logic [7:0] a);
    logic [7:0] v;
    v = p2n(inv_pow(n2p(a)));
    return v[0];
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] x);
    logic [7:0] y;
    for (int i = 0; i < N; i++)
      y[i] = x[i] ^ x[(i+4)%N] ^ x[(i+5)%N] ^ x[(i+6)%N] ^ x[(i+7)%N];
    return y ^ 8'h63;
  endfunction

  logic [7:0]    rot_q, col_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic          sbit;

  assign sbit = coord0(rot_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_q  <= '0;
      col_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        rot_q <= {rot_q[0], rot_q[7:1]};
        col_q <= {sbit, col_q[7:1]};
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(N-1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start) begin
        rot_q  <= p2n(din);
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign dout = affine(n2p(col_q));

endmodule

// File: rtl/rot_sbox_chk.sv
module rot_sbox_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [7:0] dout
);

  logic [3:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (busy) run_q <= run_q + 4'd1;
    else run_q <= '0;
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_DONE_AFTER_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_q == 4'd8)); // R3
  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < 4'd8)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(dout)); // R7

endmodule

bind rot_sbox rot_sbox_chk u_chk (.*);

// File: tb/rot_sbox_bench.sv
module rot_sbox_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] din = '0;
  logic       busy, done;
  logic [7:0] dout;

  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rot_sbox u_rot_sbox (.clk(clk), .rst_n(rst_n), .start(start), .din(din),
                       .busy(busy), .done(done), .dout(dout));

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= 16'(a) << i;
    for (int i = 15; i >= 8; i--) if (p[i]) p ^= 16'h011b << (i - 8);
    return p[7:0];
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] x);
    logic [7:0] inv, y;
    inv = '0;
    for (int c = 1; c < 256; c++) if (ref_mul(x, 8'(c)) == 8'h01) inv = 8'(c);
    y = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]};
    return y ^ 8'h63;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge with the block idle or in its done cycle
  task automatic launch(input logic [7:0] b);
    start = 1'b1;
    din = b;
    @(negedge clk);
    start = 1'b0;
    din = ~b;
  endtask

  // called at the negedge right after the loading edge
  task automatic finish_op(input logic [7:0] b, input bit junk, input bit next_now, input logic [7:0] nb);
    int cyc;
    check("R2 busy after start", 32'(busy), 32'd1);
    cyc = 0;
    while (!done && cyc < 20) begin
      if (junk && cyc == 3) begin start = 1'b1; din = b ^ 8'h5a; end
      else begin start = 1'b0; end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check("R3 done latency", 32'(cyc), 32'd8);
    check("R3 busy low in done cycle", 32'(busy), 32'd0);
    check(junk ? "R6 result after ignored start" : "R4 substitution", 32'(dout), 32'(ref_sbox(b)));
    if (next_now) begin
      launch(nb);
      check("R3 done single cycle", 32'(done), 32'd0);
    end else begin
      @(negedge clk);
      check("R3 done single cycle", 32'(done), 32'd0);
    end
  endtask

  initial begin
    logic [7:0] held, a, bq;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R1 busy at reset", 32'(busy), 32'd0);
    check("R1 done at reset", 32'(done), 32'd0);
    check("R1 dout at reset", 32'(dout), 32'h63);
    rst_n = 1'b1;
    @(negedge clk);

    launch(8'h00);
    finish_op(8'h00, 1'b0, 1'b0, 8'h00);
    check("R5 zero input", 32'(dout), 32'h63);

    for (int v = 0; v < 256; v++) begin
      launch(8'(v));
      finish_op(8'(v), 1'b0, 1'b0, 8'h00);
    end

    launch(8'h53);
    finish_op(8'h53, 1'b1, 1'b0, 8'h00);
    check("R6 ignored start gives known value", 32'(dout), 32'h ed);

    held = dout;
    for (int k = 0; k < 6; k++) begin
      din = 8'($urandom);
      @(negedge clk);
      check("R7 dout held while idle", 32'(dout), 32'(held));
    end

    a = 8'h01;
    bq = 8'hff;
    launch(a);
    begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 20) begin @(negedge clk); cyc++; end
      check("R4 first of pair", 32'(dout), 32'(ref_sbox(a)));
      launch(bq);
      check("R8 back-to-back accepted", 32'(busy), 32'd1);
      finish_op(bq, 1'b0, 1'b0, 8'h00);
    end

    for (int k = 0; k < 40; k++) begin
      logic [7:0] r;
      r = 8'($urandom);
      launch(r);
      finish_op(r, bit'($urandom % 2), 1'b0, 8'h00);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule